// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block supervises the supply of a small microcontroller and drives its core reset. Two comparator flags come in already digitized but not yet synchronized to the clock. The first says the supply is above the reset threshold. The second says the supply is above a higher warning threshold. While the supply is below the reset threshold, the core stays in reset. Once the supply rises above it, the block enables the oscillator and lets the core run only after an unbroken run of start-up clocks.

A fall below the warning threshold raises a power-fail interrupt request, if software has enabled it. A fall below the reset threshold forces reset again, and no control input can prevent this. A sticky status flag records that a power-on sequence has completed.

In stop mode, the band-gap reference is normally switched off to save current, and both supply checks are then blind. A software keep-alive bit keeps the reference and both checks working through stop mode.

Top module: `por_sequencer`

## Requirements
- R1: While the synchronized reset-threshold flag is low, `core_rst_o` is 1, `osc_en_o` is 0 and no start-up count advances.
- R2: After `sup_rst_ok_i` rises, `osc_en_o` goes to 1 on the 3rd rising clock edge. `core_rst_o` falls on edge START_CYCLES+3, which is 2 synchronizer edges, 1 state edge and START_CYCLES count edges. START_CYCLES defaults to 65536.
- R3: If the reset-threshold flag falls at any point during the start-up count, the sequencer returns to the held state. The count starts from zero on the next rise, so release again takes START_CYCLES+3 edges from that rise.
- R4: While running, a fall of `sup_rst_ok_i` makes `core_rst_o` 1 on the 3rd rising edge. No input other than stop-mode gating (R8) masks this.
- R5: `por_flag_o` is 0 after `rst_ni` and becomes 1 on the edge that releases `core_rst_o`. It stays 1 until `por_clr_i` is sampled high. If release and clear fall on the same edge, the set wins.
- R6: While running with `pfi_en_i` at 1, `pf_irq_o` rises 2 rising edges after `sup_warn_ok_i` falls. It is a level that follows the synchronized warning flag. With `pfi_en_i` at 0, it is 0.
- R7: `pf_irq_o` is never 1 while `core_rst_o` is 1.
- R8: With `stop_i` at 1 and `bg_keep_i` at 0, `bg_en_o` is 0. A running core then sees neither a power-fail reset nor a power-fail interrupt, whatever the comparator flags do.
- R9: With `stop_i` at 1 and `bg_keep_i` at 1, `bg_en_o` stays 1, and R4 and R6 keep working in stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, on-chip or external |
| rst_ni | input | 1 | Active-low asynchronous initialization of the digital state |
| sup_rst_ok_i | input | 1 | Asynchronous flag: supply above reset threshold |
| sup_warn_ok_i | input | 1 | Asynchronous flag: supply above warning threshold |
| stop_i | input | 1 | Core is in stop mode |
| bg_keep_i | input | 1 | Software bit: keep band-gap and monitor alive in stop |
| pfi_en_i | input | 1 | Power-fail interrupt enable |
| por_clr_i | input | 1 | Software clear of the power-on status flag |
| core_rst_o | output | 1 | Core reset, active high |
| osc_en_o | output | 1 | Oscillator enable |
| pf_irq_o | output | 1 | Power-fail interrupt request, level |
| por_flag_o | output | 1 | Sticky power-on-reset status |
| bg_en_o | output | 1 | Band-gap reference enable |

## Verification
A start-up counter that is off by even one shows up as a reset release one edge early or late. The bench pins this to the exact edge after each rise. A counter that fails to clear on a supply dip releases the core too early after the second rise, well before START_CYCLES+3 edges. A wrong sequencer state or wrong stop gating shows at `core_rst_o`, `pf_irq_o` or `bg_en_o` within three edges of the input change that should have mattered.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/por_startup.sv
module por_startup
  import por_pkg::*;
#(
  parameter int START_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_ok_i,
  output logic core_rst_o,
  output logic osc_en_o,
  output logic running_o,
  output logic release_o
);
  localparam int CW = (START_CYCLES > 1) ? $clog2(START_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(START_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_HOLD: begin
        cnt_d = '0;
        if (sup_ok_i) state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (!sup_ok_i) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = ST_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN: if (!sup_ok_i) state_d = ST_HOLD;
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign core_rst_o = (state_q != ST_RUN);
  assign osc_en_o   = (state_q != ST_HOLD);
  assign running_o  = (state_q == ST_RUN);
  assign release_o  = (state_q == ST_COUNT) && (state_d == ST_RUN);

  // low supply can never lead to a running core on the next edge
  p_no_run_when_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_ok_i |=> core_rst_o);
  // a dip during the count goes back to hold
  p_dip_restarts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && !sup_ok_i) |=> (state_q == ST_HOLD && cnt_q == '0));
  // release only after the last count value
  p_release_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(cnt_q) == LAST);
  // running core is forced back to reset when supply drops
  p_pf_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !sup_ok_i) |=> (core_rst_o && !osc_en_o));
endmodule

// File: rtl/por_monitor.sv
module por_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic bg_keep_i,
  input  logic pfi_en_i,
  input  logic por_clr_i,
  input  logic warn_ok_i,
  input  logic running_i,
  input  logic release_i,
  output logic bg_en_o,
  output logic pf_irq_o,
  output logic por_flag_o
);
  logic flag_q;

  assign bg_en_o  = !stop_i || bg_keep_i;
  assign pf_irq_o = running_i && bg_en_o && pfi_en_i && !warn_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (release_i) flag_q <= 1'b1;
    else if (por_clr_i) flag_q <= 1'b0;
  end
  assign por_flag_o = flag_q;

  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_flag_o && !por_clr_i) |=> por_flag_o);
  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> por_flag_o);
  p_irq_not_in_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> !pf_irq_o);
  p_bg_off_in_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !bg_keep_i) |-> (!bg_en_o && !pf_irq_o));
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int START_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_rst_ok_i,
  input  logic sup_warn_ok_i,
  input  logic stop_i,
  input  logic bg_keep_i,
  input  logic pfi_en_i,
  input  logic por_clr_i,
  output logic core_rst_o,
  output logic osc_en_o,
  output logic pf_irq_o,
  output logic por_flag_o,
  output logic bg_en_o
);
  logic [1:0] flags_s;
  logic rst_ok_s, warn_ok_s, sup_ok_eff;
  logic running, release_evt;

  por_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sup_warn_ok_i, sup_rst_ok_i}),
    .sync_o  (flags_s)
  );
  assign rst_ok_s  = flags_s[0];
  assign warn_ok_s = flags_s[1];

  // monitor blind in stop without keep-alive: treat supply as good
  assign sup_ok_eff = rst_ok_s || !bg_en_o;

  por_startup #(.START_CYCLES(START_CYCLES)) u_startup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sup_ok_i   (sup_ok_eff),
    .core_rst_o (core_rst_o),
    .osc_en_o   (osc_en_o),
    .running_o  (running),
    .release_o  (release_evt)
  );

  por_monitor u_monitor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop_i),
    .bg_keep_i  (bg_keep_i),
    .pfi_en_i   (pfi_en_i),
    .por_clr_i  (por_clr_i),
    .warn_ok_i  (warn_ok_s),
    .running_i  (running),
    .release_i  (release_evt),
    .bg_en_o    (bg_en_o),
    .pf_irq_o   (pf_irq_o),
    .por_flag_o (por_flag_o)
  );

  p_keepalive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_keep_i |-> bg_en_o);
endmodule

// File: tb/por_sequencer_tb_top.sv
module por_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sup_rst_ok_i = 1'b0, sup_warn_ok_i = 1'b0;
  logic stop_i = 1'b0, bg_keep_i = 1'b0, pfi_en_i = 1'b0, por_clr_i = 1'b0;
  logic core_rst_o, osc_en_o, pf_irq_o, por_flag_o, bg_en_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  por_sequencer #(.START_CYCLES(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sup_rst_ok_i(sup_rst_ok_i), .sup_warn_ok_i(sup_warn_ok_i),
    .stop_i(stop_i), .bg_keep_i(bg_keep_i), .pfi_en_i(pfi_en_i),
    .por_clr_i(por_clr_i),
    .core_rst_o(core_rst_o), .osc_en_o(osc_en_o), .pf_irq_o(pf_irq_o),
    .por_flag_o(por_flag_o), .bg_en_o(bg_en_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    step(1);
    chk(core_rst_o, 1'b1, "R1 core_rst in rst_ni");
    chk(osc_en_o, 1'b0, "R1 osc_en in rst_ni");
    chk(por_flag_o, 1'b0, "R5 flag after rst_ni");
    chk(pf_irq_o, 1'b0, "R7 irq in rst_ni");
    rst_ni = 1'b1;
    step(5);
    chk(core_rst_o, 1'b1, "R1 supply low holds reset");
    chk(osc_en_o, 1'b0, "R1 no count while low");
  endtask

  // drives supply high at a negedge and checks the exact release edge
  task automatic t_powerup(input string tag);
    sup_rst_ok_i = 1'b1;
    sup_warn_ok_i = 1'b1;
    step(2);
    chk(osc_en_o, 1'b0, {tag, " R2 osc_en before 3rd edge"});
    step(1);
    chk(osc_en_o, 1'b1, {tag, " R2 osc_en at 3rd edge"});
    step(N - 1);
    chk(core_rst_o, 1'b1, {tag, " R2 reset held through count"});
    step(1);
    chk(core_rst_o, 1'b0, {tag, " R2 reset released at N+3"});
    chk(por_flag_o, 1'b1, {tag, " R5 flag set on release"});
  endtask

  task automatic t_dip;
    rst_ni = 1'b0;
    sup_rst_ok_i = 1'b0;
    step(1);
    rst_ni = 1'b1;
    sup_rst_ok_i = 1'b1;
    step(20);
    sup_rst_ok_i = 1'b0;
    step(3);
    chk(osc_en_o, 1'b0, "R3 dip returns to hold");
    chk(core_rst_o, 1'b1, "R3 reset held after dip");
    t_powerup("R3 restart");
  endtask

  task automatic t_flag_clear;
    por_clr_i = 1'b1;
    step(1);
    por_clr_i = 1'b0;
    chk(por_flag_o, 1'b0, "R5 flag cleared");
    step(3);
    chk(por_flag_o, 1'b0, "R5 flag stays clear");
  endtask

  task automatic t_irq;
    pfi_en_i = 1'b1;
    sup_warn_ok_i = 1'b0;
    step(1);
    chk(pf_irq_o, 1'b0, "R6 irq not before 2nd edge");
    step(1);
    chk(pf_irq_o, 1'b1, "R6 irq raised");
    chk(core_rst_o, 1'b0, "R6 warning does not reset");
    pfi_en_i = 1'b0;
    #1;
    chk(pf_irq_o, 1'b0, "R6 irq masked by enable");
    pfi_en_i = 1'b1;
    step(1);
    sup_warn_ok_i = 1'b1;
    step(2);
    chk(pf_irq_o, 1'b0, "R6 irq drops with supply");
  endtask

  task automatic t_power_fail;
    pfi_en_i = 1'b1;
    sup_warn_ok_i = 1'b0;
    sup_rst_ok_i = 1'b0;
    step(2);
    chk(core_rst_o, 1'b0, "R4 reset not before 3rd edge");
    step(1);
    chk(core_rst_o, 1'b1, "R4 power-fail reset");
    chk(pf_irq_o, 1'b0, "R7 no irq during reset");
    step(4);
    chk(pf_irq_o, 1'b0, "R7 no irq while held");
    t_powerup("R4 recovery");
  endtask

  task automatic t_stop_blind;
    stop_i = 1'b1;
    bg_keep_i = 1'b0;
    pfi_en_i = 1'b1;
    #1;
    chk(bg_en_o, 1'b0, "R8 bg off in stop");
    sup_rst_ok_i = 1'b0;
    sup_warn_ok_i = 1'b0;
    step(6);
    chk(core_rst_o, 1'b0, "R8 no reset in blind stop");
    chk(pf_irq_o, 1'b0, "R8 no irq in blind stop");
    sup_rst_ok_i = 1'b1;
    sup_warn_ok_i = 1'b1;
    step(3);
    stop_i = 1'b0;
    #1;
    chk(bg_en_o, 1'b1, "R8 bg back on after stop");
    step(3);
    chk(core_rst_o, 1'b0, "R8 still running after stop");
  endtask

  task automatic t_stop_keep;
    stop_i = 1'b1;
    bg_keep_i = 1'b1;
    pfi_en_i = 1'b1;
    #1;
    chk(bg_en_o, 1'b1, "R9 bg kept in stop");
    sup_warn_ok_i = 1'b0;
    step(2);
    chk(pf_irq_o, 1'b1, "R9 irq in stop");
    sup_rst_ok_i = 1'b0;
    step(3);
    chk(core_rst_o, 1'b1, "R9 reset in stop");
    stop_i = 1'b0;
    bg_keep_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_powerup("R1 first");
    t_flag_clear();
    t_dip();
    t_irq();
    t_power_fail();
    t_stop_blind();
    t_stop_keep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule